// File: doc/BRIEF.md
# Root-Port Client Control Registers

This block is a small register file on an APB-style bus that sits next to a PCIe root-port core and turns software writes into the steady control levels the core needs. Each writable register keeps 16 bits. A 32-bit write changes only those low-half bits that the write data's upper half selects. Software can therefore change one field without first reading the register back.

The block drives three control levels. Root-complex mode and the training-enable level come from the general control register. The enhanced training-enable control comes from the hot-reset register. Four legacy interrupt lines are masked and merged into one level interrupt. A read-only link word brings out the core's link flags and its training state. A `link_up_o` output is high only when both flags are set and the state equals the L0 code.

Top module: `rp_client_csr`

## Requirements
- R1: A write to a writable register changes low bit n only when write data bit n+16 is 1, and then loads data bit n. Bits whose select bit is 0 keep their value.
- R2: The general control register is at offset 0x000. `rc_mode_o` follows its bit 6. `ltssm_en_o` is high only when bits 3 and 2 are both 1.
- R3: The hot-reset control register is at offset 0x180. `ltssm_enh_o` follows its bit 4.
- R4: Reading offset 0x008 returns the live `intx_i` levels in bits 3:0, with every other bit 0. Writes to 0x008 change no register and no output.
- R5: The interrupt mask register is at offset 0x01C and uses the R1 write rule. `intx_irq_o` is high while any `intx_i` line is 1 and its mask bit (bits 3:0) is 0. A mask bit of 1 blocks that line.
- R6: Reading offset 0x300 returns the physical-layer link flag in bit 16, the data-link link flag in bit 17 and the 6-bit training state in bits 5:0, with every other bit 0. Writes there have no effect.
- R7: `link_up_o` is high exactly when both link flags are 1 and the training state equals 0x11.
- R8: A read of a writable register returns its 16-bit value zero-extended to 32 bits. A read of any unmapped offset returns 0.
- R9: After reset, all three writable registers hold 0. Root-complex mode, training enable and enhanced enable are therefore low, and every interrupt line is unmasked.
- R10: `pready_o` is always 1. A write takes effect only in the access phase (select, enable and write all high), and the new value shows on the outputs after that clock edge. A setup phase on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset |
| pwdata_i | input | 32 | Write data: upper half selects bits, lower half carries values |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Always ready |
| intx_i | input | 4 | Legacy interrupt line levels |
| phy_link_i | input | 1 | Physical-layer link flag |
| dl_link_i | input | 1 | Data-link-layer link flag |
| ltssm_state_i | input | 6 | Current training state |
| rc_mode_o | output | 1 | Root-complex mode select |
| ltssm_en_o | output | 1 | Link training enable |
| ltssm_enh_o | output | 1 | Enhanced training-enable control |
| intx_irq_o | output | 1 | Combined level interrupt |
| link_up_o | output | 1 | Link is up in L0 |

## Verification
The hardest case to reach from the ports is `link_up_o` going high. It needs both flags set together with one exact value of the 6-bit state, so uniform random inputs would hit it about once in 256 draws. The stimulus therefore biases the state toward 0x11 and its near neighbours, and directed steps drop each flag on its own. Partial write selects are the second hard area. Random upper halves are mixed with directed writes whose select covers only one bit of a two-bit field. This shows that the training enable needs both bits, and that unselected bits and setup-only cycles leave the registers unchanged.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
   localparam int unsigned OFS_W = 12;
   localparam logic [OFS_W-1:0] OFS_GEN  = 12'h000;
   localparam logic [OFS_W-1:0] OFS_STAT = 12'h008;
   localparam logic [OFS_W-1:0] OFS_MASK = 12'h01C;
   localparam logic [OFS_W-1:0] OFS_HOT  = 12'h180;
   localparam logic [OFS_W-1:0] OFS_LINK = 12'h300;
   localparam int unsigned GEN_RC_BIT  = 6;
   localparam int unsigned GEN_LT_LO   = 2;
   localparam int unsigned HOT_ENH_BIT = 4;
   localparam int unsigned LINK_PHY_BIT = 16;
   localparam int unsigned LINK_DL_BIT  = 17;
endpackage

// File: rtl/wmask_reg.sv
module wmask_reg #(
   parameter int unsigned HALF = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [2*HALF-1:0] wdata_i,
   output logic [HALF-1:0]   q_o
);
   logic [HALF-1:0] sel, val;
   assign sel = wdata_i[2*HALF-1:HALF];
   assign val = wdata_i[HALF-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (wr_i) q_o <= (q_o & ~sel) | (val & sel);
   end

   // R1
   selected_bits_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((q_o & $past(sel)) == ($past(val) & $past(sel))));
   // R1
   unselected_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> ((q_o & ~$past(sel)) == ($past(q_o) & ~$past(sel))));
   // R10
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(q_o));
endmodule

// File: rtl/intx_combine.sv
module intx_combine #(
   parameter int unsigned NUM_LINES = 4,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_LINES-1:0] line_i,
   input  logic [NUM_LINES-1:0] block_i,
   output logic                 irq_o
);
   logic pending;
   assign pending = |(line_i & ~block_i);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= pending;
      end
      // R5
      all_blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&block_i) |=> !irq_o);
   end else begin : g_comb
      assign irq_o = pending;
      // R5
      all_blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&block_i) |-> !irq_o);
      // R5
      open_line_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (line_i[0] && !block_i[0]) |-> irq_o);
   end
endmodule

// File: rtl/link_decode.sv
module link_decode #(
   parameter int unsigned        STATE_W = 6,
   parameter logic [STATE_W-1:0] L0_CODE = 6'h11
) (
   input  logic               phy_up_i,
   input  logic               dl_up_i,
   input  logic [STATE_W-1:0] state_i,
   output logic               link_up_o,
   output logic [31:0]        word_o
);
   always_comb begin
      word_o = '0;
      word_o[STATE_W-1:0]            = state_i;
      word_o[rpc_pkg::LINK_PHY_BIT]  = phy_up_i;
      word_o[rpc_pkg::LINK_DL_BIT]   = dl_up_i;
   end
   assign link_up_o = phy_up_i & dl_up_i & (state_i == L0_CODE);
endmodule

// File: rtl/rp_client_csr.sv
module rp_client_csr #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_INTX  = 4,
   parameter int unsigned STATE_W   = 6,
   parameter logic [5:0]  L0_CODE   = 6'h11,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               psel_i,
   input  logic               penable_i,
   input  logic               pwrite_i,
   input  logic [ADDR_W-1:0]  paddr_i,
   input  logic [DATA_W-1:0]  pwdata_i,
   output logic [DATA_W-1:0]  prdata_o,
   output logic               pready_o,
   input  logic [NUM_INTX-1:0] intx_i,
   input  logic               phy_link_i,
   input  logic               dl_link_i,
   input  logic [STATE_W-1:0] ltssm_state_i,
   output logic               rc_mode_o,
   output logic               ltssm_en_o,
   output logic               ltssm_enh_o,
   output logic               intx_irq_o,
   output logic               link_up_o
);
   import rpc_pkg::*;

   localparam int unsigned HALF = DATA_W / 2;

   if (DATA_W != 32) begin : g_bad_data
      $error("rp_client_csr: DATA_W must be 32");
   end
   if (ADDR_W != OFS_W) begin : g_bad_addr
      $error("rp_client_csr: ADDR_W must equal the offset width");
   end
   if (NUM_INTX > HALF || STATE_W > LINK_PHY_BIT) begin : g_bad_fit
      $error("rp_client_csr: fields do not fit the register layout");
   end

   logic            wr_acc;
   logic            we_gen, we_mask, we_hot;
   logic [HALF-1:0] gen_q, mask_q, hot_q;
   logic [31:0]     link_word;

   assign pready_o = 1'b1;
   assign wr_acc   = psel_i & penable_i & pwrite_i;
   assign we_gen   = wr_acc && (paddr_i == OFS_GEN);
   assign we_mask  = wr_acc && (paddr_i == OFS_MASK);
   assign we_hot   = wr_acc && (paddr_i == OFS_HOT);

   wmask_reg #(.HALF(HALF)) i_gen  (.clk_i, .rst_ni, .wr_i(we_gen),  .wdata_i(pwdata_i), .q_o(gen_q));
   wmask_reg #(.HALF(HALF)) i_mask (.clk_i, .rst_ni, .wr_i(we_mask), .wdata_i(pwdata_i), .q_o(mask_q));
   wmask_reg #(.HALF(HALF)) i_hot  (.clk_i, .rst_ni, .wr_i(we_hot),  .wdata_i(pwdata_i), .q_o(hot_q));

   assign rc_mode_o   = gen_q[GEN_RC_BIT];
   assign ltssm_en_o  = &gen_q[GEN_LT_LO+1:GEN_LT_LO];
   assign ltssm_enh_o = hot_q[HOT_ENH_BIT];

   intx_combine #(.NUM_LINES(NUM_INTX), .IRQ_REG(IRQ_REG)) i_intx (
      .clk_i, .rst_ni, .line_i(intx_i), .block_i(mask_q[NUM_INTX-1:0]), .irq_o(intx_irq_o));

   link_decode #(.STATE_W(STATE_W), .L0_CODE(L0_CODE[STATE_W-1:0])) i_link (
      .phy_up_i(phy_link_i), .dl_up_i(dl_link_i), .state_i(ltssm_state_i),
      .link_up_o(link_up_o), .word_o(link_word));

   always_comb begin
      prdata_o = '0;
      case (paddr_i)
         OFS_GEN:  prdata_o[HALF-1:0]     = gen_q;
         OFS_STAT: prdata_o[NUM_INTX-1:0] = intx_i;
         OFS_MASK: prdata_o[HALF-1:0]     = mask_q;
         OFS_HOT:  prdata_o[HALF-1:0]     = hot_q;
         OFS_LINK: prdata_o               = link_word;
         default:  prdata_o = '0;
      endcase
   end

   // R7
   link_needs_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_up_o |-> (phy_link_i && dl_link_i && ltssm_state_i == L0_CODE[STATE_W-1:0]));
   // R7
   l0_with_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phy_link_i && dl_link_i && ltssm_state_i == L0_CODE[STATE_W-1:0]) |-> link_up_o);
   // R2
   enable_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ltssm_en_o |-> (prdata_o[3:2] == 2'b11 || paddr_i != OFS_GEN));
   // R8
   unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (paddr_i != OFS_GEN && paddr_i != OFS_STAT && paddr_i != OFS_MASK &&
       paddr_i != OFS_HOT && paddr_i != OFS_LINK) |-> (prdata_o == '0));
endmodule

// File: tb/test_rp_client_csr.sv
module test_rp_client_csr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic [3:0]  intx = '0;
   logic        phy_up = 1'b0, dl_up = 1'b0;
   logic [5:0]  state = '0;
   logic        rc_mode, lt_en, lt_enh, irq, link_up;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [15:0] m_gen = '0, m_mask = '0, m_hot = '0;

   always #5 clk = ~clk;

   rp_client_csr i_rp_client_csr (
      .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
      .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
      .intx_i(intx), .phy_link_i(phy_up), .dl_link_i(dl_up), .ltssm_state_i(state),
      .rc_mode_o(rc_mode), .ltssm_en_o(lt_en), .ltssm_enh_o(lt_enh),
      .intx_irq_o(irq), .link_up_o(link_up));

   function automatic logic [15:0] wm(input logic [15:0] old, input logic [31:0] d);
      return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [11:0] a);
      case (a)
         12'h000: return {16'h0, m_gen};
         12'h008: return {28'h0, intx};
         12'h01C: return {16'h0, m_mask};
         12'h180: return {16'h0, m_hot};
         12'h300: return {14'h0, dl_up, phy_up, 10'h0, state};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outs(input string req);
      check({req, " rc_mode R2"}, {31'h0, rc_mode}, {31'h0, m_gen[6]});
      check({req, " ltssm_en R2"}, {31'h0, lt_en}, {31'h0, m_gen[3] & m_gen[2]});
      check({req, " enh R3"}, {31'h0, lt_enh}, {31'h0, m_hot[4]});
      check({req, " irq R5"}, {31'h0, irq}, {31'h0, |(intx & ~m_mask[3:0])});
      check({req, " link R7"}, {31'h0, link_up}, {31'h0, phy_up & dl_up & (state == 6'h11)});
      check({req, " ready R10"}, {31'h0, pready}, 32'h1);
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
      case (a)
         12'h000: m_gen  = wm(m_gen, d);
         12'h01C: m_mask = wm(m_mask, d);
         12'h180: m_hot  = wm(m_hot, d);
         default: ;
      endcase
   endtask

   task automatic bus_rd_chk(input logic [11:0] a, input string req);
      @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(negedge clk); penable = 1;
      #1 check(req, prdata, exp_rd(a));
      @(negedge clk); psel = 0; penable = 0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h5EED_1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check_outs("R9 reset");
      bus_rd_chk(12'h000, "R9 gen zero");
      bus_rd_chk(12'h01C, "R9 mask zero");
      bus_rd_chk(12'h180, "R9 hot zero");
      intx = 4'hF; #1 check("R9 unmasked irq", {31'h0, irq}, 32'h1);
      intx = 4'h0;

      // R2 / R1 field writes
      bus_wr(12'h000, 32'h0040_0040); check_outs("R2 rc set");
      bus_wr(12'h000, 32'h000C_0004); check_outs("R2 half enable");
      check("R2 half enable low", {31'h0, lt_en}, 32'h0);
      bus_wr(12'h000, 32'h0008_0008); check_outs("R2 full enable");
      check("R2 enable high", {31'h0, lt_en}, 32'h1);
      bus_wr(12'h000, 32'h0000_FFFF); check_outs("R1 no select");
      bus_rd_chk(12'h000, "R1 gen readback");
      check("R1 gen value", {16'h0, m_gen}, 32'h4C);

      // R10 setup phase only
      @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h000; pwdata = 32'hFFFF_0000;
      @(negedge clk); psel = 0; pwrite = 0;
      @(negedge clk); check_outs("R10 setup only");
      bus_rd_chk(12'h000, "R10 gen unchanged");

      // R3
      bus_wr(12'h180, 32'h0010_0010); check_outs("R3 enh set");
      check("R3 enh high", {31'h0, lt_enh}, 32'h1);

      // R4 status read-only
      intx = 4'hA;
      bus_wr(12'h008, 32'hFFFF_FFFF); check_outs("R4 write ignored");
      bus_rd_chk(12'h008, "R4 status level");

      // R5 mask
      bus_wr(12'h01C, 32'h000F_000F); intx = 4'hF; #1 check_outs("R5 all masked");
      bus_wr(12'h01C, 32'h0004_0000); intx = 4'h4; #1 check_outs("R5 line2 open");
      check("R5 irq high", {31'h0, irq}, 32'h1);
      intx = 4'h1; #1 check_outs("R5 line0 blocked");
      bus_rd_chk(12'h01C, "R5 mask readback");

      // R6 / R7 link
      phy_up = 1; dl_up = 1; state = 6'h11; #1 check_outs("R7 l0");
      check("R7 link high", {31'h0, link_up}, 32'h1);
      bus_rd_chk(12'h300, "R6 link word");
      bus_wr(12'h300, 32'hFFFF_FFFF); bus_rd_chk(12'h300, "R6 write ignored");
      state = 6'h10; #1 check_outs("R7 wrong state");
      state = 6'h11; dl_up = 0; #1 check_outs("R7 dl low");
      dl_up = 1; phy_up = 0; #1 check_outs("R7 phy low");

      // R8 unmapped
      bus_rd_chk(12'h004, "R8 unmapped 004");
      bus_rd_chk(12'h2FC, "R8 unmapped 2FC");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         case ($urandom % 7)
            0: a = 12'h000; 1: a = 12'h008; 2: a = 12'h01C;
            3: a = 12'h180; 4: a = 12'h300; 5: a = 12'h000;
            default: a = 12'($urandom);
         endcase
         d = $urandom;
         intx = 4'($urandom);
         phy_up = ($urandom % 4) != 0;
         dl_up  = ($urandom % 4) != 0;
         state  = ($urandom % 2) ? 6'h11 : (($urandom % 2) ? 6'($urandom) : 6'h10);
         if ($urandom % 2) bus_wr(a, d);
         else bus_rd_chk(a, "R8 random read");
         check_outs("R1 random");
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule